// File: doc/BRIEF.md
# Single-Wire Search Triplet Unit

This unit carries out one branch decision of the binary search that enumerates device identifiers on a single-wire bus. When asked, it runs two read slots through an attached bit-slot engine. The first slot returns the identifier bit of every device still taking part. The second returns that bit's complement. From the pair it picks a direction and sends it back in one write slot, so that devices whose bit differs drop out.

The caller gives a preferred direction with each request. That bit is used only when the two reads show a conflict, meaning both values are present on the bus. The result is a 3-bit status code with a one-cycle done strobe. An all-ones read pair means no device answered. In that case no write slot is run and the caller has to restart the search. The outer search loop, discrepancy bookkeeping and identifier storage are left to the caller.

Top module: `single_wire_triplet`

## Requirements
- R1: After reset the unit is idle, with `slotReq` low and `done` low.
- R2: An accepted request issues two read slots (`slotWr`=0), in this order: the identifier bit first, then its complement. No write slot is started before both reads have completed (`slotDone` seen twice).
- R3: The status packs the identifier bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2. When `done` is high, the status is always one of 0, 2, 3, 4 or 5.
- R4: When both reads return 0, the direction taken is the preferred direction latched at request time. The status is 4 if that direction is 1, and 0 otherwise.
- R5: When both reads return 1, the status is 3 and no write slot is issued.
- R6: When exactly one read returns 1, the direction taken equals the identifier bit. The status is 5 if the identifier bit is 1, and 2 if the complement bit is 1.
- R7: For a non-error decision, exactly one write slot (`slotWr`=1) carries the direction on `slotBit`. `done` is a single-cycle pulse, once per request. It follows completion of the write slot, or of the second read in the error case.
- R8: A `start` pulse while a request is in progress is ignored. It starts no further slots, produces no extra `done`, and does not change the preferred direction in use.
- R9: `slotReq` and `slotWr` stay stable until `slotReady` accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a triplet step (taken only when idle) |
| prefDir | input | 1 | Preferred direction, used when both reads are 0 |
| status | output | 3 | {direction, complement bit, identifier bit}, valid with `done` |
| done | output | 1 | One-cycle completion strobe |
| slotReq | output | 1 | Slot request to the bit-slot engine |
| slotWr | output | 1 | 1 = write slot, 0 = read slot |
| slotBit | output | 1 | Bit to write (1 during read slots) |
| slotReady | input | 1 | Engine accepts the pending slot request |
| slotDone | input | 1 | Engine finished the accepted slot |
| slotRdBit | input | 1 | Bus level sampled in the finished slot |

## Verification
The unit has no size parameters, because its 3-bit code is fixed, so the bench builds it exactly as it stands. The stress comes from the engine model, which delays acceptance and completion of each slot by zero to two cycles at random. This exposes both the back-to-back handshake paths and the held-request path. Random read pairs and preferred directions reach all five status codes many times over. Directed cases add mid-operation `start` pulses and the all-ones restart condition.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int STATUS_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ID, ST_WT_ID, ST_RD_CMP, ST_WT_CMP, ST_DECIDE, ST_WR, ST_WT_WR
  } tripState_t;

  typedef struct packed {
    logic takePref;
    logic takeId;
    logic takeCmp;
  } tripCtrl_t;
endpackage

// File: rtl/trip_dp.sv
module trip_dp
  import trip_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tripCtrl_t           ctrl,
  input  logic                prefDir,
  input  logic                rdBit,
  output logic                dirBit,
  output logic                errFlag,
  output logic [STATUS_W-1:0] status
);
  logic idQ, cmpQ, prefQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ   <= 1'b0;
      cmpQ  <= 1'b0;
      prefQ <= 1'b0;
    end else begin
      if (ctrl.takePref) prefQ <= prefDir;
      if (ctrl.takeId)   idQ   <= rdBit;
      if (ctrl.takeCmp)  cmpQ  <= rdBit;
    end
  end

  always_comb begin
    errFlag = idQ & cmpQ;
    if (errFlag)          dirBit = 1'b0;
    else if (idQ ^ cmpQ)  dirBit = idQ;
    else                  dirBit = prefQ;
    status = {dirBit, cmpQ, idQ};
  end

  // R4
  pref_used_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idQ && !cmpQ) |-> (status[2] == prefQ));
endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
  import trip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      errFlag,
  input  logic      slotReady,
  input  logic      slotDone,
  output tripCtrl_t ctrl,
  output logic      slotReq,
  output logic      slotWr,
  output logic      done
);
  tripState_t st, stNext;
  logic doneNext;

  always_comb begin
    stNext   = st;
    ctrl     = '0;
    slotReq  = 1'b0;
    slotWr   = 1'b0;
    doneNext = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        ctrl.takePref = 1'b1;
        stNext = ST_RD_ID;
      end
      ST_RD_ID: begin
        slotReq = 1'b1;
        if (slotReady) stNext = ST_WT_ID;
      end
      ST_WT_ID: if (slotDone) begin
        ctrl.takeId = 1'b1;
        stNext = ST_RD_CMP;
      end
      ST_RD_CMP: begin
        slotReq = 1'b1;
        if (slotReady) stNext = ST_WT_CMP;
      end
      ST_WT_CMP: if (slotDone) begin
        ctrl.takeCmp = 1'b1;
        stNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (errFlag) begin
          doneNext = 1'b1;
          stNext = ST_IDLE;
        end else begin
          stNext = ST_WR;
        end
      end
      ST_WR: begin
        slotReq = 1'b1;
        slotWr  = 1'b1;
        if (slotReady) stNext = ST_WT_WR;
      end
      ST_WT_WR: if (slotDone) begin
        doneNext = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= stNext;
      done <= doneNext;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotReady) |=> (slotReq && $stable(slotWr)));
endmodule

// File: rtl/single_wire_triplet.sv
module single_wire_triplet
  import trip_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                prefDir,
  output logic [STATUS_W-1:0] status,
  output logic                done,
  output logic                slotReq,
  output logic                slotWr,
  output logic                slotBit,
  input  logic                slotReady,
  input  logic                slotDone,
  input  logic                slotRdBit
);
  tripCtrl_t ctrl;
  logic dirBit, errFlag;

  trip_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .errFlag(errFlag),
    .slotReady(slotReady), .slotDone(slotDone), .ctrl(ctrl),
    .slotReq(slotReq), .slotWr(slotWr), .done(done)
  );

  trip_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .prefDir(prefDir),
    .rdBit(slotRdBit), .dirBit(dirBit), .errFlag(errFlag), .status(status)
  );

  assign slotBit = slotWr ? dirBit : 1'b1;

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (status inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5}));

  // R5
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && slotWr) |-> !(status[0] && status[1]));

  // R6
  write_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && slotWr) |-> (slotBit == status[2]));
endmodule

// File: tb/single_wire_triplet_tb.sv
module single_wire_triplet_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, prefDir = 1'b0;
  logic [2:0] status;
  logic done, slotReq, slotWr, slotBit;
  logic slotReady = 1'b0, slotDone = 1'b0, slotRdBit = 1'b0;

  int checks = 0, errors = 0;
  int rdCnt = 0, wrCnt = 0, doneCnt = 0;
  logic wrBitSeen = 1'b0, orderBad = 1'b0;
  logic idVal = 1'b0, cmpVal = 1'b0;

  always #10 clk = ~clk;

  single_wire_triplet u_dut (
    .clk(clk), .rstN(rstN), .start(start), .prefDir(prefDir),
    .status(status), .done(done), .slotReq(slotReq), .slotWr(slotWr),
    .slotBit(slotBit), .slotReady(slotReady), .slotDone(slotDone),
    .slotRdBit(slotRdBit)
  );

  function automatic logic [2:0] expStatus(logic id, logic cmp, logic pref);
    if (id && cmp)        return 3'd3;
    else if (!id && !cmp) return pref ? 3'd4 : 3'd0;
    else                  return id ? 3'd5 : 3'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-slot engine model with random handshake delays
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && slotReq) begin
        repeat ($urandom % 3) @(negedge clk);
        slotReady = 1'b1;
        if (slotWr) begin
          if (rdCnt != 2) orderBad = 1'b1;
          wrCnt++;
          wrBitSeen = slotBit;
        end else begin
          if (wrCnt != 0) orderBad = 1'b1;
          rdCnt++;
        end
        @(negedge clk);
        slotReady = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        slotRdBit = (rdCnt == 1) ? idVal : cmpVal;
        slotDone = 1'b1;
        @(negedge clk);
        slotDone = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) doneCnt++;
  end

  task automatic runOp(input logic id, input logic cmp, input logic pref, input bit inject);
    logic [2:0] e;
    int d0;
    e = expStatus(id, cmp, pref);
    idVal = id; cmpVal = cmp;
    rdCnt = 0; wrCnt = 0; orderBad = 1'b0;
    d0 = doneCnt;
    @(negedge clk);
    start = 1'b1; prefDir = pref;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (2) @(negedge clk);
      start = 1'b1; prefDir = ~pref;
      @(negedge clk);
      start = 1'b0; prefDir = pref;
    end
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk(done === 1'b1, "R7 done", int'(done), 1);
    if (id && cmp) chk(status == e, "R5 status", status, e);
    else if (!id && !cmp) chk(status == e, "R4 status", status, e);
    else chk(status == e, "R6 R3 status", status, e);
    @(negedge clk);
    chk(done == 1'b0, "R7 pulse width", done, 0);
    repeat (8) @(negedge clk);
    chk(rdCnt == 2, "R2 read count", rdCnt, 2);
    chk(!orderBad, "R2 slot order", orderBad, 0);
    chk(wrCnt == ((id && cmp) ? 0 : 1), "R5 R7 write count", wrCnt, (id && cmp) ? 0 : 1);
    if (!(id && cmp)) chk(wrBitSeen == e[2], "R6 write bit", wrBitSeen, e[2]);
    chk(doneCnt - d0 == 1, inject ? "R8 done count" : "R7 done count", doneCnt - d0, 1);
    chk(slotReq == 1'b0, "R8 idle after op", slotReq, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(slotReq == 1'b0, "R1 slotReq", slotReq, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(slotReq == 1'b0 && done == 1'b0, "R1 idle", slotReq, 0);
    // directed corners
    runOp(1'b0, 1'b0, 1'b1, 1'b0);
    runOp(1'b0, 1'b0, 1'b0, 1'b0);
    runOp(1'b1, 1'b0, 1'b0, 1'b0);
    runOp(1'b0, 1'b1, 1'b1, 1'b0);
    runOp(1'b1, 1'b1, 1'b1, 1'b0);
    runOp(1'b0, 1'b0, 1'b1, 1'b1);
    runOp(1'b0, 1'b0, 1'b0, 1'b1);
    runOp(1'b1, 1'b1, 1'b0, 1'b1);
    // random mix
    for (int n = 0; n < 60; n++)
      runOp(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule